// File: doc/BRIEF.md
# Verified Boot Sequencer

This controller orders a secure boot. After power-on reset it keeps the system in reset until both the logic self-test and the memory self-test report that they are done. If either of them failed, the system stays in reset for good. If both passed, the controller goes through two stages: bootloader first, then firmware. Each stage has two image slots, A and B. The controller ranks the slots by their version fields and asks an external checker to verify the signature of the preferred slot. If that check fails, it asks for the other slot. If both slots fail, it freezes for good.

Signature verification and flash reads happen outside this block. The block drives a level request that carries the stage and slot. The checker answers with a one-cycle acknowledge and a pass bit. If no acknowledge comes within a bounded number of cycles, the check counts as failed. After the firmware passes, the block emits a single launch strobe with the entry address of the chosen slot. It also reports a stage code and the slot picked at each stage.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While either self-test has not yet reported done, `hold_rst` is 1 and `sig_req` is 0. After reset, `stage` is 0 (self-test) and `frozen` and `launch` are 0.
- R2: If either self-test reports a failure, the block enters hold. In hold, `stage` is 1 and `hold_rst` stays at 1 until reset. No signature request is ever issued, whatever the inputs do later.
- R3: In each stage the slot with the higher version is requested first. On equal versions slot A goes first. A version of all ones ranks below every other value, and if both are all ones, A goes first.
- R4: An acknowledge with `sig_ok`=0 makes the block request the other slot of the same stage. If the second slot also fails, the block freezes.
- R5: A request that gets no acknowledge within ACK_TIMEOUT cycles counts as a failed check.
- R6: The firmware stage (`sig_stage`=1) starts only after a bootloader slot passes. It uses the same ranking and fallback rules. `sig_stage` is 0 during the bootloader stage, and `sig_slot` is 0 for A and 1 for B.
- R7: `launch` is a one-cycle pulse. It is issued only after a firmware check passes. `launch_addr` is FW_ADDR_A for slot A and FW_ADDR_B for slot B. After the pulse, `stage` is 4 (running).
- R8: In freeze, `frozen` stays at 1 and `stage` stays at 5 until reset. No request and no launch occur in freeze.
- R9: `bl_slot` and `fw_slot` report the slot that passed at each stage. `stage` encodes self-test 0, hold 1, bootloader 2, firmware 3, running 4, frozen 5. At most one of `launch`, `frozen` and `hold_rst` is 1 at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| lbist_done | input | 1 | Logic self-test finished |
| lbist_pass | input | 1 | Logic self-test result, valid with done |
| mbist_done | input | 1 | Memory self-test finished |
| mbist_pass | input | 1 | Memory self-test result, valid with done |
| bl_ver_a | input | VER_W | Bootloader slot A version |
| bl_ver_b | input | VER_W | Bootloader slot B version |
| fw_ver_a | input | VER_W | Firmware slot A version |
| fw_ver_b | input | VER_W | Firmware slot B version |
| sig_req | output | 1 | Signature check request (level) |
| sig_stage | output | 1 | Stage being checked: 0 bootloader, 1 firmware |
| sig_slot | output | 1 | Slot being checked: 0 A, 1 B |
| sig_ack | input | 1 | Check answered (one cycle) |
| sig_ok | input | 1 | Signature valid, sampled with ack |
| hold_rst | output | 1 | Keep system in reset |
| frozen | output | 1 | Terminal freeze |
| launch | output | 1 | One-cycle jump strobe |
| launch_addr | output | ADDR_W | Entry address of verified firmware |
| bl_slot | output | 1 | Bootloader slot that passed |
| fw_slot | output | 1 | Firmware slot that passed |
| stage | output | 3 | Stage code |

## Verification
The bench builds the block with ACK_TIMEOUT=16. At that value a silent checker times out within a few dozen cycles, so single and double timeouts in both stages can be exercised alongside explicit rejections. Distinct non-zero FW_ADDR_A and FW_ADDR_B values make a launch from the wrong slot visible. An 8-bit version width keeps the all-ones "invalid" code easy to drive in the ranking cases.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [3:0] {
    ST_SELFTEST,
    ST_HOLD,
    ST_BL_FIRST,
    ST_BL_ALT,
    ST_FW_FIRST,
    ST_FW_ALT,
    ST_LAUNCH,
    ST_RUN,
    ST_FREEZE
  } boot_state_e;

  localparam logic [2:0] STG_SELFTEST = 3'd0;
  localparam logic [2:0] STG_HOLD     = 3'd1;
  localparam logic [2:0] STG_BL       = 3'd2;
  localparam logic [2:0] STG_FW       = 3'd3;
  localparam logic [2:0] STG_RUN      = 3'd4;
  localparam logic [2:0] STG_FREEZE   = 3'd5;
endpackage

// File: rtl/boot_slot_rank.sv
// Chooses which of two image slots to verify first.
module boot_slot_rank #(
  parameter int VER_W = 8
) (
  input  logic [VER_W-1:0] ver_a,
  input  logic [VER_W-1:0] ver_b,
  output logic             pick_b
);
  logic a_valid;
  logic b_valid;

  always_comb begin
    a_valid = ~&ver_a;
    b_valid = ~&ver_b;
    // B wins only when valid and strictly newer (or A is invalid); ties go to A
    pick_b  = b_valid && (!a_valid || (ver_b > ver_a));
  end
endmodule

// File: rtl/boot_ack_timer.sv
// Counts cycles of an outstanding request; flags expiry after LIMIT cycles.
module boot_ack_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    expired = run && (cnt_q == LAST);
    cnt_en  = clr || (run && !expired);
    cnt_d   = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= LAST));
  assert_timer_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> run);
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int                VER_W       = 8,
  parameter int                ADDR_W      = 32,
  parameter int                ACK_TIMEOUT = 1024,
  parameter logic [ADDR_W-1:0] FW_ADDR_A   = 'h0000_0000,
  parameter logic [ADDR_W-1:0] FW_ADDR_B   = 'h0008_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lbist_done,
  input  logic              lbist_pass,
  input  logic              mbist_done,
  input  logic              mbist_pass,
  input  logic [VER_W-1:0]  bl_ver_a,
  input  logic [VER_W-1:0]  bl_ver_b,
  input  logic [VER_W-1:0]  fw_ver_a,
  input  logic [VER_W-1:0]  fw_ver_b,
  output logic              sig_req,
  output logic              sig_stage,
  output logic              sig_slot,
  input  logic              sig_ack,
  input  logic              sig_ok,
  output logic              hold_rst,
  output logic              frozen,
  output logic              launch,
  output logic [ADDR_W-1:0] launch_addr,
  output logic              bl_slot,
  output logic              fw_slot,
  output logic [2:0]        stage
);
  boot_state_e state_q, state_d;
  logic lb_done_q, lb_pass_q, mb_done_q, mb_pass_q;
  logic bl_first_q, fw_first_q, bl_slot_q, fw_slot_q;
  logic bl_first_d, fw_first_d, bl_slot_d, fw_slot_d;
  logic bl_pick_b, fw_pick_b;
  logic tmo_expired, tmo_clr;
  logic try_ok, try_done;
  logic lb_cap, mb_cap;

  boot_slot_rank #(.VER_W(VER_W)) u_rank_bl (
    .ver_a(bl_ver_a), .ver_b(bl_ver_b), .pick_b(bl_pick_b));
  boot_slot_rank #(.VER_W(VER_W)) u_rank_fw (
    .ver_a(fw_ver_a), .ver_b(fw_ver_b), .pick_b(fw_pick_b));

  boot_ack_timer #(.LIMIT(ACK_TIMEOUT)) u_ack_timer (
    .clk(clk), .rst_n(rst_n), .run(sig_req), .clr(tmo_clr),
    .expired(tmo_expired));

  // Self-test result capture
  always_comb begin
    lb_cap = lbist_done && !lb_done_q;
    mb_cap = mbist_done && !mb_done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_done_q <= 1'b0;
      lb_pass_q <= 1'b0;
    end else if (lb_cap) begin
      lb_done_q <= 1'b1;
      lb_pass_q <= lbist_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_done_q <= 1'b0;
      mb_pass_q <= 1'b0;
    end else if (mb_cap) begin
      mb_done_q <= 1'b1;
      mb_pass_q <= mbist_pass;
    end
  end

  // Next-state logic
  always_comb begin
    try_ok     = sig_ack && sig_ok;
    try_done   = sig_ack || tmo_expired;
    state_d    = state_q;
    bl_first_d = bl_first_q;
    fw_first_d = fw_first_q;
    bl_slot_d  = bl_slot_q;
    fw_slot_d  = fw_slot_q;
    unique case (state_q)
      ST_SELFTEST: if (lb_done_q && mb_done_q) begin
        if (lb_pass_q && mb_pass_q) begin
          state_d    = ST_BL_FIRST;
          bl_first_d = bl_pick_b;
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_BL_FIRST, ST_BL_ALT: if (try_ok) begin
        state_d    = ST_FW_FIRST;
        bl_slot_d  = (state_q == ST_BL_ALT) ? !bl_first_q : bl_first_q;
        fw_first_d = fw_pick_b;
      end else if (try_done) begin
        state_d = (state_q == ST_BL_ALT) ? ST_FREEZE : ST_BL_ALT;
      end
      ST_FW_FIRST, ST_FW_ALT: if (try_ok) begin
        state_d   = ST_LAUNCH;
        fw_slot_d = (state_q == ST_FW_ALT) ? !fw_first_q : fw_first_q;
      end else if (try_done) begin
        state_d = (state_q == ST_FW_ALT) ? ST_FREEZE : ST_FW_ALT;
      end
      ST_LAUNCH: state_d = ST_RUN;
      default:   state_d = state_q;
    endcase
    tmo_clr = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_SELFTEST;
      bl_first_q <= 1'b0;
      fw_first_q <= 1'b0;
      bl_slot_q  <= 1'b0;
      fw_slot_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      bl_first_q <= bl_first_d;
      fw_first_q <= fw_first_d;
      bl_slot_q  <= bl_slot_d;
      fw_slot_q  <= fw_slot_d;
    end
  end

  // Outputs
  always_comb begin
    sig_req     = (state_q == ST_BL_FIRST) || (state_q == ST_BL_ALT) ||
                  (state_q == ST_FW_FIRST) || (state_q == ST_FW_ALT);
    sig_stage   = (state_q == ST_FW_FIRST) || (state_q == ST_FW_ALT);
    unique case (state_q)
      ST_BL_FIRST: sig_slot = bl_first_q;
      ST_BL_ALT:   sig_slot = !bl_first_q;
      ST_FW_FIRST: sig_slot = fw_first_q;
      ST_FW_ALT:   sig_slot = !fw_first_q;
      default:     sig_slot = 1'b0;
    endcase
    hold_rst    = (state_q == ST_SELFTEST) || (state_q == ST_HOLD);
    frozen      = (state_q == ST_FREEZE);
    launch      = (state_q == ST_LAUNCH);
    launch_addr = fw_slot_q ? FW_ADDR_B : FW_ADDR_A;
    bl_slot     = bl_slot_q;
    fw_slot     = fw_slot_q;
    unique case (state_q)
      ST_SELFTEST:           stage = STG_SELFTEST;
      ST_HOLD:               stage = STG_HOLD;
      ST_BL_FIRST, ST_BL_ALT: stage = STG_BL;
      ST_FW_FIRST, ST_FW_ALT: stage = STG_FW;
      ST_LAUNCH, ST_RUN:     stage = STG_RUN;
      default:               stage = STG_FREEZE;
    endcase
  end

  assert_no_req_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |-> !sig_req);
  assert_hold_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == STG_HOLD) |=> (stage == STG_HOLD) && hold_rst);
  assert_freeze_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> frozen && !sig_req && !launch);
  assert_launch_verified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(sig_req && sig_stage && sig_ack && sig_ok));
  assert_launch_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch && (stage == STG_RUN));
  assert_fw_after_bl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_stage) |-> $past(sig_ack && sig_ok && !sig_stage));
  assert_outcomes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch, frozen, hold_rst}));
endmodule

// File: tb/boot_seq_ctrl_tb.sv
module boot_seq_ctrl_tb;
  localparam int VER_W = 8;
  localparam int ADDR_W = 32;
  localparam int TMO = 16;
  localparam logic [31:0] ADDR_A = 32'h0001_0040;
  localparam logic [31:0] ADDR_B = 32'h0002_0080;
  localparam logic [7:0] K_REQ = 8'd1, K_LAUNCH = 8'd2, K_FREEZE = 8'd3, K_HOLD = 8'd4;
  localparam int R_OK = 0, R_BAD = 1, R_SILENT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic lbist_done, lbist_pass, mbist_done, mbist_pass;
  logic [VER_W-1:0] bl_ver_a, bl_ver_b, fw_ver_a, fw_ver_b;
  logic sig_req, sig_stage, sig_slot, sig_ack, sig_ok;
  logic hold_rst, frozen, launch, bl_slot, fw_slot;
  logic [ADDR_W-1:0] launch_addr;
  logic [2:0] stage;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  logic [39:0] exp_q[$];
  string tag_q[$];
  int resp_q[$];

  always #4 clk = ~clk;

  boot_seq_ctrl #(.VER_W(VER_W), .ADDR_W(ADDR_W), .ACK_TIMEOUT(TMO),
    .FW_ADDR_A(ADDR_A), .FW_ADDR_B(ADDR_B)) u_dut (
    .clk(clk), .rst_n(rst_n), .lbist_done(lbist_done), .lbist_pass(lbist_pass),
    .mbist_done(mbist_done), .mbist_pass(mbist_pass), .bl_ver_a(bl_ver_a),
    .bl_ver_b(bl_ver_b), .fw_ver_a(fw_ver_a), .fw_ver_b(fw_ver_b),
    .sig_req(sig_req), .sig_stage(sig_stage), .sig_slot(sig_slot),
    .sig_ack(sig_ack), .sig_ok(sig_ok), .hold_rst(hold_rst), .frozen(frozen),
    .launch(launch), .launch_addr(launch_addr), .bl_slot(bl_slot),
    .fw_slot(fw_slot), .stage(stage));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input string tag, input logic [7:0] kind, input logic [31:0] val);
    exp_q.push_back({kind, val});
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [39:0] it);
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R4 unexpected event act=%0h exp=none", it);
    end else begin
      logic [39:0] e = exp_q.pop_front();
      string t = tag_q.pop_front();
      chk(t, it, e);
    end
  endtask

  // Monitor and checker responder
  logic prev_req, prev_frz, prev_hold;
  logic [1:0] prev_tag;
  int wait_c;
  bit ok_v;
  initial begin
    sig_ack = 0; sig_ok = 0; prev_req = 0; prev_frz = 0; prev_hold = 0;
    prev_tag = 0; wait_c = 0; ok_v = 0;
    forever begin
      @(negedge clk);
      sig_ack = 0;
      if (rst_n !== 1'b1) begin
        prev_req = 0; prev_frz = 0; prev_hold = 0; wait_c = 0;
      end else begin
        if (launch) observe({K_LAUNCH, launch_addr});
        if (frozen && !prev_frz) observe({K_FREEZE, 32'd0});
        if (stage == 3'd1 && !prev_hold) observe({K_HOLD, 32'd0});
        prev_frz = frozen;
        prev_hold = (stage == 3'd1);
        if (sig_req && (!prev_req || {sig_stage, sig_slot} != prev_tag)) begin
          int r;
          observe({K_REQ, 30'd0, sig_stage, sig_slot});
          r = (resp_q.size() != 0) ? resp_q.pop_front() : R_OK;
          wait_c = (r == R_SILENT) ? 0 : 2;
          ok_v = (r == R_OK);
        end else if (wait_c > 0) begin
          wait_c--;
          if (wait_c == 0) begin
            sig_ack = 1; sig_ok = ok_v;
          end
        end
        prev_req = sig_req;
        prev_tag = {sig_stage, sig_slot};
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    lbist_done = 0; lbist_pass = 0; mbist_done = 0; mbist_pass = 0;
    bl_ver_a = 0; bl_ver_b = 0; fw_ver_a = 0; fw_ver_b = 0;
    exp_q.delete(); tag_q.delete(); resp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_boot(input logic [7:0] ba, input logic [7:0] bb,
                          input logic [7:0] fa, input logic [7:0] fb,
                          input logic lp, input logic mp);
    bl_ver_a = ba; bl_ver_b = bb; fw_ver_a = fa; fw_ver_b = fb;
    lbist_done = 1; lbist_pass = lp; mbist_done = 1; mbist_pass = mp;
    for (int i = 0; i < 300 && !(stage == 3'd4 || stage == 3'd5 || stage == 3'd1); i++)
      @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R4 all expected events seen", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    do_reset();
    // Reset state and waiting for self-tests
    chk("R1 hold_rst after reset", 64'(hold_rst), 64'd1);
    chk("R1 frozen after reset", 64'(frozen), 64'd0);
    chk("R1 launch after reset", 64'(launch), 64'd0);
    chk("R9 stage after reset", 64'(stage), 64'd0);
    lbist_done = 1; lbist_pass = 1;
    repeat (6) @(negedge clk);
    chk("R1 no request with one self-test pending", 64'(sig_req), 64'd0);
    chk("R1 still held with one self-test pending", 64'(hold_rst), 64'd1);

    // Newer bootloader B, newer firmware A, all pass
    do_reset();
    expect_item("R3 bl newer B first", K_REQ, 32'd1);
    expect_item("R6 fw newer A first", K_REQ, 32'd2);
    expect_item("R7 launch slot A", K_LAUNCH, ADDR_A);
    resp_q = '{R_OK, R_OK};
    run_boot(8'd3, 8'd5, 8'd7, 8'd2, 1, 1);
    chk("R9 bl_slot", 64'(bl_slot), 64'd1);
    chk("R9 fw_slot", 64'(fw_slot), 64'd0);
    chk("R7 running stage", 64'(stage), 64'd4);
    chk("R7 launch single pulse", 64'(launch), 64'd0);
    chk("R9 hold released", 64'(hold_rst), 64'd0);

    // Tie picks A, rejection falls back; invalid fw A ranks lowest
    do_reset();
    expect_item("R3 tie picks A", K_REQ, 32'd0);
    expect_item("R4 fallback to B", K_REQ, 32'd1);
    expect_item("R3 invalid A ranked lowest", K_REQ, 32'd3);
    expect_item("R7 launch slot B", K_LAUNCH, ADDR_B);
    resp_q = '{R_BAD, R_OK, R_OK};
    run_boot(8'd4, 8'd4, 8'hFF, 8'd1, 1, 1);
    chk("R9 bl_slot after fallback", 64'(bl_slot), 64'd1);
    chk("R9 fw_slot B", 64'(fw_slot), 64'd1);

    // Both firmware images rejected
    do_reset();
    expect_item("R3 invalid B ranked lowest", K_REQ, 32'd0);
    expect_item("R6 fw newer A", K_REQ, 32'd2);
    expect_item("R6 fw fallback B", K_REQ, 32'd3);
    expect_item("R4 both fw fail freeze", K_FREEZE, 32'd0);
    resp_q = '{R_OK, R_BAD, R_BAD};
    run_boot(8'd2, 8'hFF, 8'd9, 8'd3, 1, 1);
    bl_ver_a = 8'd1; fw_ver_b = 8'd50;
    repeat (30) @(negedge clk);
    chk("R8 frozen sticky", 64'(frozen), 64'd1);
    chk("R8 no request in freeze", 64'(sig_req), 64'd0);
    chk("R8 stage frozen", 64'(stage), 64'd5);

    // Timeouts count as failures
    do_reset();
    expect_item("R5 bl B first", K_REQ, 32'd1);
    expect_item("R5 bl timeout falls back to A", K_REQ, 32'd0);
    expect_item("R5 fw tie A", K_REQ, 32'd2);
    expect_item("R5 fw timeout to B", K_REQ, 32'd3);
    expect_item("R5 double timeout freeze", K_FREEZE, 32'd0);
    resp_q = '{R_SILENT, R_OK, R_SILENT, R_SILENT};
    run_boot(8'd1, 8'd2, 8'd5, 8'd5, 1, 1);
    chk("R5 bl_slot A after timeout", 64'(bl_slot), 64'd0);

    // Logic self-test failure
    do_reset();
    expect_item("R2 lbist fail hold", K_HOLD, 32'd0);
    run_boot(8'd1, 8'd2, 8'd3, 8'd4, 0, 1);
    lbist_pass = 1;
    repeat (30) @(negedge clk);
    chk("R2 hold_rst sticky", 64'(hold_rst), 64'd1);
    chk("R2 no request in hold", 64'(sig_req), 64'd0);
    chk("R2 stage hold", 64'(stage), 64'd1);

    // Memory self-test failure
    do_reset();
    expect_item("R2 mbist fail hold", K_HOLD, 32'd0);
    run_boot(8'd1, 8'd2, 8'd3, 8'd4, 1, 0);
    chk("R2 hold after mbist fail", 64'(hold_rst), 64'd1);

    // All versions invalid: A first
    do_reset();
    expect_item("R3 both invalid bl picks A", K_REQ, 32'd0);
    expect_item("R3 both invalid fw picks A", K_REQ, 32'd2);
    expect_item("R7 launch A", K_LAUNCH, ADDR_A);
    resp_q = '{R_OK, R_OK};
    run_boot(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1, 1);
    chk("R7 launch_addr held", 64'(launch_addr), 64'(ADDR_A));

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule